// File: doc/BRIEF.md
# Big-Endian Masked Memory Port

This block is the load/store path between a 32-bit core and a byte-wide RAM. The RAM holds 2^ADDR_BITS bytes. The core issues one request per transfer: a direction, an access size (byte, halfword or word), a signedness flag for loads, a 32-bit address and 32 bits of store data. The block moves the data one byte per clock and raises `done` for one cycle when the transfer is complete.

Every address is reduced modulo the memory size, so accesses wrap. The block never raises a fault for an unaligned address. It clears the low address bits to reach the natural boundary: bit 0 for halfwords, bits 1:0 for words. Multi-byte values are laid out in big-endian order, with the most significant byte at the lowest address. Loaded bytes and halfwords come back either sign-extended or zero-extended.

Top module: `bemem_unit`

## Requirements
- R1: After reset, `done` is 0 and `rdata` is 0.
- R2: Only address bits ADDR_BITS-1:0 select a byte. Addresses that differ only above that range reach the same byte.
- R3: A halfword access ignores address bit 0. A word access ignores address bits 1:0.
- R4: A word is stored and loaded with bits 31:24 at the aligned address, then 23:16, 15:8 and 7:0 at the next three addresses.
- R5: A halfword is stored and loaded with bits 15:8 at the aligned address and bits 7:0 at the next address. A store writes `wdata[15:0]`.
- R6: A byte load returns the byte in `rdata[7:0]`. Bits 31:8 are copies of bit 7 when `ld_signed` is 1 and zeros when it is 0. A byte store writes `wdata[7:0]`.
- R7: A halfword load fills `rdata[31:16]` with copies of bit 15 when `ld_signed` is 1 and with zeros when it is 0.
- R8: `done` is high for exactly one cycle. It follows the request edge after 1, 2 or 4 further clock edges for a byte, halfword or word access respectively.
- R9: A request presented while a transfer is in progress is ignored and changes no memory byte.
- R10: Size code 11 behaves exactly as a word access (code 10). Code 00 is byte and code 01 is halfword.
- R11: `rdata` changes only when a load completes. It holds its value through stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a transfer (sampled only when idle) |
| wr_en | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| ld_signed | input | 1 | Sign-extend a byte or halfword load |
| addr | input | 32 | Byte address before masking and alignment |
| wdata | input | 32 | Store data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Extended load result |

## Verification
The assertions assume a request is a single-cycle pulse. They also assume `acc_size`, `wr_en` and `ld_signed` matter only in the cycle the request is accepted. The bench drives every request for exactly one cycle, between clock edges. It then waits for `done` before starting the next transfer. There is one exception: the R9 test deliberately pulses a request in the middle of a word transfer. The sweeps use a 64-byte memory, so every byte, halfword and word location is covered, along with wrap aliases taken from upper address bits.

// File: rtl/bemem_unit.sv
module bemem_unit #(
  parameter int ADDR_BITS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr_en,
  input  logic [1:0]  acc_size,
  input  logic        ld_signed,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        done,
  output logic [31:0] rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [7:0]           mem [DEPTH];
  logic                 busy;
  logic [1:0]           idx, last_q, sz_q;
  logic [ADDR_BITS-1:0] base_q;
  logic                 wr_q, sgn_q;
  logic [31:0]          wd_q;
  logic [23:0]          acc;

  wire [1:0] sz_n   = (acc_size == 2'b11) ? 2'b10 : acc_size;
  wire [1:0] last_n = (sz_n == 2'b10) ? 2'd3 : (sz_n == 2'b01) ? 2'd1 : 2'd0;
  wire [ADDR_BITS-1:0] lo_clr = ADDR_BITS'(last_n);
  wire [ADDR_BITS-1:0] base_n = addr[ADDR_BITS-1:0] & ~lo_clr;
  wire [ADDR_BITS-1:0] cur    = base_q | ADDR_BITS'(idx);
  wire [7:0]  rd_byte = mem[cur];
  wire [31:0] word    = {acc, rd_byte};
  wire        accept  = req && !busy;
  wire        finish  = busy && (idx == last_q);

  logic [31:0] ext;
  always_comb begin
    case (sz_q)
      2'b00:   ext = {{24{sgn_q & word[7]}}, word[7:0]};
      2'b01:   ext = {{16{sgn_q & word[15]}}, word[15:0]};
      default: ext = word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; last_q <= '0; sz_q <= '0;
      base_q <= '0; wr_q <= 1'b0; sgn_q <= 1'b0; wd_q <= '0;
      acc <= '0; done <= 1'b0; rdata <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        idx    <= '0;
        last_q <= last_n;
        sz_q   <= sz_n;
        base_q <= base_n;
        wr_q   <= wr_en;
        sgn_q  <= ld_signed;
        wd_q   <= wdata << (8 * (3 - last_n));
        acc    <= '0;
      end else if (busy) begin
        idx  <= idx + 2'd1;
        wd_q <= {wd_q[23:0], 8'h00};
        acc  <= {acc[15:0], rd_byte};
        if (finish) begin
          busy <= 1'b0;
          if (!wr_q) rdata <= ext;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && wr_q) mem[cur] <= wd_q[31:24];
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
  a_r9_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != last_q) |=> busy && $stable(base_q) && $stable(wr_q));
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sz_q == 2'b10) |-> base_q[1:0] == 2'b00);
  a_r6_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_q && !sgn_q && sz_q == 2'b00) |-> rdata[31:8] == 24'h0);
  a_r7_half_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_q && !sgn_q && sz_q == 2'b01) |-> rdata[31:16] == 16'h0);
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_q) |=> $stable(rdata));
endmodule

// File: tb/test_bemem_unit.sv
module test_bemem_unit;
  localparam int AB = 6;
  localparam int N  = 1 << AB;

  logic clk = 0, rst_n = 0, req = 0, wr_en = 0, ld_signed = 0, done;
  logic [1:0]  acc_size = 0;
  logic [31:0] addr = 0, wdata = 0, rdata;
  int checks = 0, errors = 0, ncyc = 0;
  logic [7:0] model [N];

  always #10 clk = ~clk;

  bemem_unit #(.ADDR_BITS(AB)) i_bemem_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .acc_size(acc_size),
    .ld_signed(ld_signed), .addr(addr), .wdata(wdata), .done(done), .rdata(rdata));

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expect_ld(input logic [1:0] s, input logic sg, input logic [31:0] a);
    int n = nb(s);
    int al = int'(a % N) & ~(n - 1);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v = (v << 8) | 32'(model[al + i]);
    if (n == 1) v = sg ? {{24{v[7]}}, v[7:0]} : v & 32'hff;
    if (n == 2) v = sg ? {{16{v[15]}}, v[15:0]} : v & 32'hffff;
    return v;
  endfunction

  task automatic model_st(input logic [1:0] s, input logic [31:0] a, input logic [31:0] d);
    int n = nb(s);
    int al = int'(a % N) & ~(n - 1);
    for (int i = 0; i < n; i++) model[al + i] = 8'(d >> (8 * (n - 1 - i)));
  endtask

  task automatic xfer(input logic w, input logic [1:0] s, input logic sg,
                      input logic [31:0] a, input logic [31:0] d, output int lat);
    @(negedge clk);
    req = 1; wr_en = w; acc_size = s; ld_signed = sg; addr = a; wdata = d;
    lat = 0;
    @(negedge clk);
    req = 0; wr_en = 0; acc_size = 0; ld_signed = 0; addr = 0; wdata = 0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    if (w) model_st(s, a, d);
  endtask

  task automatic ld(input string tag, input logic [1:0] s, input logic sg, input logic [31:0] a);
    int lat;
    logic [31:0] e = expect_ld(s, sg, a);
    xfer(0, s, sg, a, 0, lat);
    chk(tag, rdata, e);
  endtask

  initial begin
    int lat;
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1;

    // R6: fill through byte stores, with high bits set in some addresses (R2)
    for (int a = 0; a < N; a++) xfer(1, 2'b00, 0, 32'(a) | 32'(a << 10), 32'hABCD_0000 | 32'((a * 73 + 19) & 255), lat);
    for (int a = 0; a < N; a++) ld("R6 byte unsigned", 2'b00, 0, 32'(a));
    for (int a = 0; a < N; a++) ld("R6 byte signed", 2'b00, 1, 32'(a) + 32'h8000_0000);
    // R5/R7/R3: every halfword, odd addresses alias to even
    for (int a = 0; a < N; a++) ld("R7 R3 half unsigned", 2'b01, 0, 32'(a));
    for (int a = 0; a < N; a++) ld("R7 R5 half signed", 2'b01, 1, 32'(a) | 32'h0001_0000);
    // R4/R3/R10: every word at every offset, both word codes
    for (int a = 0; a < N; a++) ld("R4 R3 word", 2'b10, 0, 32'(a));
    for (int a = 0; a < N; a++) ld("R10 word code 11", 2'b11, 1, 32'(a) + 32'(N * 5));
    // R4: word store order, misaligned address
    xfer(1, 2'b10, 0, 32'h21 + 32'(N), 32'h1122_3344, lat);
    chk("R8 word store latency", 32'(lat), 5);
    for (int i = 0; i < 4; i++) ld("R4 store byte order", 2'b00, 0, 32'h20 + 32'(i));
    // R5: half store order, only low 16 bits used
    xfer(1, 2'b01, 0, 32'h13, 32'hDEAD_F00D, lat);
    chk("R8 half store latency", 32'(lat), 3);
    ld("R5 half store hi", 2'b00, 0, 32'h12);
    ld("R5 half store lo", 2'b00, 0, 32'h13);
    chk("R5 half store model", expect_ld(2'b01, 0, 32'h12), 32'h0000_F00D);
    // R10: word store via code 11
    xfer(1, 2'b11, 0, 32'h2E, 32'h8899_AABB, lat);
    chk("R10 latency", 32'(lat), 5);
    ld("R10 word store readback", 2'b10, 0, 32'h2C);
    // R8 latencies of loads
    xfer(0, 2'b00, 0, 32'h5, 0, lat); chk("R8 byte latency", 32'(lat), 2);
    xfer(0, 2'b01, 0, 32'h5, 0, lat); chk("R8 half latency", 32'(lat), 3);
    xfer(0, 2'b10, 0, 32'h5, 0, lat); chk("R8 word latency", 32'(lat), 5);
    @(negedge clk); chk("R8 done single", {31'b0, done}, 0);
    // R11: rdata held across a store
    ld("R11 load", 2'b10, 0, 32'h30);
    prev = rdata;
    xfer(1, 2'b10, 0, 32'h34, 32'h0102_0304, lat);
    chk("R11 rdata hold", rdata, prev);
    // R9: request during a word transfer is ignored
    @(negedge clk);
    req = 1; wr_en = 1; acc_size = 2'b10; addr = 32'h0; wdata = 32'h5555_AAAA;
    @(negedge clk);
    acc_size = 2'b00; addr = 32'h08; wdata = 32'h0000_00EE;
    @(negedge clk);
    req = 0; wr_en = 0; acc_size = 0; addr = 0; wdata = 0;
    while (!done) @(negedge clk);
    model_st(2'b10, 0, 32'h5555_AAAA);
    ld("R9 ignored byte store", 2'b00, 0, 32'h08);
    ld("R9 accepted word", 2'b10, 0, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule